// File: doc/BRIEF.md
# Cached-Head Ring Buffer Controller

This block is a four-entry first-in first-out queue whose storage is split in two. The oldest entry always sits in a local head register, so the output port can present it with no storage access. The remaining three entries live in an external array of single-entry storage cells, numbered 1 to 3. The controller reaches these cells through separate write and read request/acknowledge handshakes.

Values enter through a valid/ready input port and leave through a valid/ready output port. When the queue is empty, the first value goes straight into the head register. Later values are written into the cell at the write pointer. After each dequeue, the controller reads the cell at the read pointer to refill the head register. Both pointers step through the sequence 1, 2, 3, 1, and so on.

Only one transaction runs at a time. While a cell handshake is outstanding, both ports are held off. When a dequeue and an enqueue are both possible in the same idle cycle, the dequeue is served first.

Top module: `ringHeadFifo`

## Requirements
- R1: After reset the queue is empty: outValid is 0, inReady is 1, and neither cell request is raised. The first cell written and the first cell read both have index 1.
- R2: A value accepted while the queue is empty is loaded into the head register without any cell request. outValid is 1 in the next cycle, with that value on outData.
- R3: A value accepted while the queue holds 1 to 3 entries raises cellWrReq in the next cycle, with that value on cellWrData. cellWrReq, cellWrIdx and cellWrData stay stable until the cycle in which cellWrAck is 1. While any cell request is raised, inReady and outValid are 0.
- R4: Successive cell writes use indices 1, 2, 3, 1, 2, 3, and so on.
- R5: inReady is 0 whenever the queue holds 4 entries.
- R6: outValid is 1 exactly when the controller is idle and the queue is not empty. outData then shows the oldest queued value, so values leave in the order they entered.
- R7: A dequeue that leaves at least one entry behind raises cellRdReq in the next cycle, and cellRdReq stays stable until cellRdAck is 1. The cellRdData value returned with the acknowledge appears on outData in the following cycle.
- R8: Successive cell reads use indices 1, 2, 3, 1, 2, 3, and so on.
- R9: A dequeue of the last entry raises no cell request, and outValid is 0 in the next cycle.
- R10: In an idle cycle where outValid and outReady are both 1, inReady is 0, so the dequeue wins over a simultaneous enqueue.
- R11: cellWrReq and cellRdReq are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input value offered |
| inReady | output | 1 | Input value will be taken this cycle |
| inData | input | DATA_W | Input value |
| outValid | output | 1 | Head value offered |
| outReady | input | 1 | Consumer takes the head value this cycle |
| outData | output | DATA_W | Head value |
| cellWrReq | output | 1 | Write request to a storage cell |
| cellWrIdx | output | IDX_W | Index (1..RING_CELLS) of the cell being written |
| cellWrData | output | DATA_W | Value to store |
| cellWrAck | input | 1 | Cell has stored the value |
| cellRdReq | output | 1 | Read request to a storage cell |
| cellRdIdx | output | IDX_W | Index (1..RING_CELLS) of the cell being read |
| cellRdAck | input | 1 | Cell returns its value this cycle |
| cellRdData | input | DATA_W | Value returned by the cell |

## Verification
inReady depends combinationally on outReady in the same cycle. For that reason the bench sets the ready and valid inputs at the falling edge, waits a step, and then compares inReady. A request-raising fire shows its cell request one edge later. A head load from a bypass or a read acknowledge shows on outData one edge later. The bench keeps a queue model that advances only after each rising edge, and it compares every output at the following falling edge, so each result is checked exactly in the cycle it is due. Cell acknowledges are delayed at random to stretch the handshakes. A directed fill and a directed contention window cover the full and output-first cases.

// File: rtl/ringFifoPkg.sv
package ringFifoPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic headFromIn;
    logic headFromCell;
    logic latchWr;
    logic advWr;
    logic advRd;
  } dpStrobes_t;

endpackage

// File: rtl/ringFifoPtr.sv
module ringFifoPtr #(
  parameter int unsigned SLOTS = 3,
  parameter int unsigned PTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] FIRST = PTR_W'(1);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(SLOTS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= FIRST;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? FIRST : ptr + FIRST;
    end
  end
endmodule

// File: rtl/ringFifoDatapath.sv
module ringFifoDatapath
  import ringFifoPkg::*;
#(
  parameter int unsigned DATA_W     = 2,
  parameter int unsigned RING_CELLS = 3,
  parameter int unsigned IDX_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] cellRdData,
  output logic [DATA_W-1:0] headData,
  output logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headData <= '0;
    end else if (strobes.headFromIn) begin
      headData <= inData;
    end else if (strobes.headFromCell) begin
      headData <= cellRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrData <= '0;
    end else if (strobes.latchWr) begin
      wrData <= inData;
    end
  end

  ringFifoPtr #(.SLOTS(RING_CELLS), .PTR_W(IDX_W)) wrPtr_i (
    .clk (clk),
    .rstN(rstN),
    .adv (strobes.advWr),
    .ptr (wrIdx)
  );

  ringFifoPtr #(.SLOTS(RING_CELLS), .PTR_W(IDX_W)) rdPtr_i (
    .clk (clk),
    .rstN(rstN),
    .adv (strobes.advRd),
    .ptr (rdIdx)
  );

endmodule

// File: rtl/ringFifoCtrl.sv
module ringFifoCtrl
  import ringFifoPkg::*;
#(
  parameter int unsigned CAP   = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             cellWrAck,
  input  logic             cellRdAck,
  output logic             inReady,
  output logic             outValid,
  output logic             cellWrReq,
  output logic             cellRdReq,
  output dpStrobes_t       strobes,
  output logic [CNT_W-1:0] occCount
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CAP);

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] countNext;
  logic idle, outFire, inFire, isEmpty;

  always_comb begin
    idle     = (state == ST_IDLE);
    isEmpty  = (occCount == '0);
    outValid = idle && !isEmpty;
    outFire  = outValid && outReady;
    inReady  = idle && (occCount < FULL) && !outFire;
    inFire   = inValid && inReady;
    cellWrReq = (state == ST_WRITE);
    cellRdReq = (state == ST_READ);

    strobes.headFromIn   = inFire && isEmpty;
    strobes.latchWr      = inFire && !isEmpty;
    strobes.headFromCell = cellRdReq && cellRdAck;
    strobes.advWr        = cellWrReq && cellWrAck;
    strobes.advRd        = cellRdReq && cellRdAck;
  end

  always_comb begin
    stateNext = state;
    countNext = occCount;
    unique case (state)
      ST_IDLE: begin
        if (outFire) begin
          if (occCount == ONE) countNext = '0;
          else                 stateNext = ST_READ;
        end else if (inFire) begin
          if (isEmpty) countNext = ONE;
          else         stateNext = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (cellWrAck) begin
          countNext = occCount + ONE;
          stateNext = ST_IDLE;
        end
      end
      ST_READ: begin
        if (cellRdAck) begin
          countNext = occCount - ONE;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      occCount <= '0;
    end else begin
      state    <= stateNext;
      occCount <= countNext;
    end
  end

endmodule

// File: rtl/ringHeadFifo.sv
module ringHeadFifo
  import ringFifoPkg::*;
#(
  parameter int unsigned DATA_W     = 2,
  parameter int unsigned RING_CELLS = 3,
  localparam int unsigned CAP       = RING_CELLS + 1,
  localparam int unsigned IDX_W     = $clog2(RING_CELLS + 1),
  localparam int unsigned CNT_W     = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              cellWrReq,
  output logic [IDX_W-1:0]  cellWrIdx,
  output logic [DATA_W-1:0] cellWrData,
  input  logic              cellWrAck,
  output logic              cellRdReq,
  output logic [IDX_W-1:0]  cellRdIdx,
  input  logic              cellRdAck,
  input  logic [DATA_W-1:0] cellRdData
);

  dpStrobes_t       strobes;
  logic [CNT_W-1:0] occCount;

  ringFifoCtrl #(.CAP(CAP), .CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .cellWrAck(cellWrAck),
    .cellRdAck(cellRdAck),
    .inReady  (inReady),
    .outValid (outValid),
    .cellWrReq(cellWrReq),
    .cellRdReq(cellRdReq),
    .strobes  (strobes),
    .occCount (occCount)
  );

  ringFifoDatapath #(.DATA_W(DATA_W), .RING_CELLS(RING_CELLS), .IDX_W(IDX_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .cellRdData(cellRdData),
    .headData  (outData),
    .wrData    (cellWrData),
    .wrIdx     (cellWrIdx),
    .rdIdx     (cellRdIdx)
  );

endmodule

// File: rtl/ringHeadFifoChk.sv
module ringHeadFifoChk #(
  parameter int unsigned DATA_W = 2,
  parameter int unsigned CAP    = 4,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              cellWrReq,
  input logic [IDX_W-1:0]  cellWrIdx,
  input logic [DATA_W-1:0] cellWrData,
  input logic              cellWrAck,
  input logic              cellRdReq,
  input logic [IDX_W-1:0]  cellRdIdx,
  input logic              cellRdAck,
  input logic [DATA_W-1:0] cellRdData,
  input logic [CNT_W-1:0]  occCount
);

  a_r11_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(cellWrReq && cellRdReq));

  a_r3_busy_ports_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cellWrReq || cellRdReq) |-> (!inReady && !outValid));

  a_r3_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cellWrReq && !cellWrAck) |=> (cellWrReq && $stable(cellWrIdx) && $stable(cellWrData)));

  a_r3_write_entry: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && occCount != '0) |=> (cellWrReq && cellWrData == $past(inData)));

  a_r7_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cellRdReq && !cellRdAck) |=> (cellRdReq && $stable(cellRdIdx)));

  a_r7_head_reload: assert property (@(posedge clk) disable iff (!rstN)
    (cellRdReq && cellRdAck) |=> (outValid && outData == $past(cellRdData)));

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && occCount == '0) |=> (outValid && !cellWrReq && outData == $past(inData)));

  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (occCount == CNT_W'(CAP)) |-> !inReady);

  a_r9_last_out: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && occCount == CNT_W'(1)) |=> (!outValid && !cellRdReq));

  a_r10_output_first: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> !inReady);

endmodule

bind ringHeadFifo ringHeadFifoChk #(
  .DATA_W(DATA_W), .CAP(CAP), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .inData    (inData),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .cellWrReq (cellWrReq),
  .cellWrIdx (cellWrIdx),
  .cellWrData(cellWrData),
  .cellWrAck (cellWrAck),
  .cellRdReq (cellRdReq),
  .cellRdIdx (cellRdIdx),
  .cellRdAck (cellRdAck),
  .cellRdData(cellRdData),
  .occCount  (occCount)
);

// File: tb/ringHeadFifo_tb_top.sv
module ringHeadFifo_tb_top;
  localparam int DW    = 8;
  localparam int CELLS = 3;
  localparam int CAP   = CELLS + 1;
  localparam int IW    = 2;
  localparam int NCYC  = 3000;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inReady, outValid, outReady;
  logic [DW-1:0] inData, outData, cellWrData, cellRdData;
  logic cellWrReq, cellWrAck, cellRdReq, cellRdAck;
  logic [IW-1:0] cellWrIdx, cellRdIdx;

  always #4 clk = ~clk;

  ringHeadFifo #(.DATA_W(DW), .RING_CELLS(CELLS)) dut_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .cellWrReq(cellWrReq), .cellWrIdx(cellWrIdx), .cellWrData(cellWrData), .cellWrAck(cellWrAck),
    .cellRdReq(cellRdReq), .cellRdIdx(cellRdIdx), .cellRdAck(cellRdAck), .cellRdData(cellRdData)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Model state
  logic [DW-1:0] mq [0:CAP-1];
  logic [DW-1:0] cells [1:CELLS];
  int mCnt = 0;
  int expWr = 1;
  int expRd = 1;
  int phase = 0;            // 0 idle, 1 writing, 2 reading
  logic [DW-1:0] pend;
  bit justBypassed = 1'b0;
  bit justEmptied  = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nextPtr(input int p);
    return (p == CELLS) ? 1 : p + 1;
  endfunction

  function automatic bit expInReady(input int cnt, input bit oRdy);
    return (cnt < CAP) && !((cnt > 0) && oRdy);
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit outFire, inFire, wAck, rAck;
    void'($urandom(32'd24681));
    rstN = 1'b0; inValid = 1'b0; inData = '0; outReady = 1'b0;
    cellWrAck = 1'b0; cellRdAck = 1'b0; cellRdData = '0;
    for (int i = 1; i <= CELLS; i++) cells[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", outValid, 0);
    chk(inReady == 1'b1, "R1", inReady, 1);
    chk(cellWrReq == 1'b0 && cellRdReq == 1'b0, "R1", {cellWrReq, cellRdReq}, 0);
    rstN = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      cellWrAck = 1'b0; cellRdAck = 1'b0;
      outFire = 1'b0; inFire = 1'b0; wAck = 1'b0; rAck = 1'b0;

      if (cyc < 30) begin
        inValid = 1'b1; outReady = 1'b0;
      end else if (cyc < 60) begin
        inValid = 1'b1; outReady = 1'b1;
      end else if (cyc < NCYC - 60) begin
        inValid = ($urandom_range(0, 1) == 1); outReady = ($urandom_range(0, 1) == 1);
      end else begin
        inValid = 1'b0; outReady = 1'b1;
      end
      inData = DW'($urandom_range(0, 255));
      #1;

      chk(!(cellWrReq && cellRdReq), "R11", {cellWrReq, cellRdReq}, 0);

      if (justBypassed) begin
        chk(cellWrReq == 1'b0, "R2", cellWrReq, 0);
        chk(outValid == 1'b1, "R2", outValid, 1);
        chk(outData == mq[0], "R2", outData, mq[0]);
      end
      if (justEmptied) begin
        chk(cellRdReq == 1'b0, "R9", cellRdReq, 0);
        chk(outValid == 1'b0, "R9", outValid, 0);
      end
      justBypassed = 1'b0; justEmptied = 1'b0;

      if (phase == 0) begin
        chk(outValid == (mCnt > 0), "R6", outValid, (mCnt > 0));
        if (mCnt > 0) chk(outData == mq[0], "R6", outData, mq[0]);
        chk(!cellWrReq && !cellRdReq, "R11", {cellWrReq, cellRdReq}, 0);
        if (mCnt == CAP)
          chk(inReady == 1'b0, "R5", inReady, 0);
        else if (mCnt > 0 && outReady)
          chk(inReady == 1'b0, "R10", inReady, 0);
        else
          chk(inReady == expInReady(mCnt, outReady), "R6", inReady, expInReady(mCnt, outReady));
        outFire = (mCnt > 0) && outReady;
        inFire  = inValid && expInReady(mCnt, outReady);
      end else if (phase == 1) begin
        chk(cellWrReq == 1'b1, "R3", cellWrReq, 1);
        chk(cellWrIdx == IW'(expWr), "R4", cellWrIdx, expWr);
        chk(cellWrData == pend, "R3", cellWrData, pend);
        chk(!inReady && !outValid, "R3", {inReady, outValid}, 0);
        wAck = ($urandom_range(0, 1) == 1);
        cellWrAck = wAck;
      end else begin
        chk(cellRdReq == 1'b1, "R7", cellRdReq, 1);
        chk(cellRdIdx == IW'(expRd), "R8", cellRdIdx, expRd);
        chk(!inReady && !outValid, "R3", {inReady, outValid}, 0);
        rAck = ($urandom_range(0, 1) == 1);
        cellRdAck = rAck;
        cellRdData = cells[expRd];
      end

      @(posedge clk);
      if (phase == 0) begin
        if (outFire) begin
          for (int k = 0; k < CAP - 1; k++) mq[k] = mq[k+1];
          mCnt--;
          if (mCnt == 0) justEmptied = 1'b1;
          else phase = 2;
        end else if (inFire) begin
          if (mCnt == 0) begin
            mq[0] = inData; mCnt = 1; justBypassed = 1'b1;
          end else begin
            pend = inData; phase = 1;
          end
        end
      end else if (phase == 1 && wAck) begin
        cells[expWr] = pend;
        mq[mCnt] = pend;
        mCnt++;
        expWr = nextPtr(expWr);
        phase = 0;
      end else if (phase == 2 && rAck) begin
        expRd = nextPtr(expRd);
        phase = 0;
      end
    end

    @(negedge clk);
    chk(mCnt == 0 && outValid == 1'b0, "R6", outValid, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule